// File: doc/BRIEF.md
# Audio Link Interrupt Status Aggregator

This block gathers the interrupt sources of an audio link controller and presents them in one 32-bit read-only status word. Each of eight streams (four capture, four playback) provides a small group of status flags. The block ORs each group into a per-stream summary bit. Three controller-level sources are ORed into a controller summary bit: a response has arrived, the response buffer has overrun, and a serial data-in line has changed state. A global bit ORs every summary bit together. The summaries ignore the enable bits. The interrupt line to the host is driven only when a set summary has its own enable set and the master enable is on. That line is registered so that it cannot glitch.

The same small read port also returns a free-running wall clock count. This 32-bit counter advances once per link bit-clock period while its run control is set. It wraps to zero, clears on controller reset, and can be preloaded. Reads are strobed and return data one cycle later. A power-state wake indication has no effect on the status word or the interrupt line.

Top module: `audirq_hub`

## Requirements
- R1: After controller reset (rst_n low), irq is 0, the wall count is 0, and read data is 0.
- R2: Status bit 31 is 1 exactly when any of status bits 30..0 is 1.
- R3: Status bit 30 is the OR of rsp_flag, rsp_ovr_flag and sdin_chg_flag.
- R4: Status bits 3..0 are capture streams 0..3 and bits 7..4 are playback streams 0..3. Each bit is the OR of that stream's STRM_FLAGS flags, where stream s uses flags [s*STRM_FLAGS +: STRM_FLAGS] of its bus.
- R5: Status bits 29..8 always read as 0.
- R6: The summary bits are the same whatever the values of strm_en, ctl_en and glb_en.
- R7: irq is 1 in the cycle after an edge at which glb_en=1 and some summary bit has its enable set (strm_en[k] for bit k, ctl_en for bit 30). Otherwise irq is 0 after that edge.
- R8: wake_evt changes neither the status word nor irq.
- R9: The wall count increases by 1 at each edge where wall_en=1 and link_tick=1. At all other edges it holds its value, unless a preload occurs.
- R10: The wall count wraps from FFFFFFFFh to 00000000h. When wall_load=1, the count takes wall_load_val at that edge, and this has priority over counting.
- R11: rd_data is updated at the edge where rd_stb=1. It holds the status word for address 24h, the wall count for address 30h, and 0 for any other address. It holds its value while no strobe occurs.
- R12: Controller reset clears the wall count to 0, even after it has counted or been preloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Controller reset, active low |
| wake_evt | input | 1 | Pulse marking a wake from the low-power hot state |
| link_tick | input | 1 | One pulse per link bit-clock period |
| wall_en | input | 1 | Wall clock run control |
| wall_load | input | 1 | Preload strobe for the wall count |
| wall_load_val | input | 32 | Preload value |
| cap_flags | input | 4*STRM_FLAGS | Capture stream status flags |
| play_flags | input | 4*STRM_FLAGS | Playback stream status flags |
| rsp_flag | input | 1 | Response received |
| rsp_ovr_flag | input | 1 | Response buffer overrun |
| sdin_chg_flag | input | 1 | Serial data-in state change |
| strm_en | input | 8 | Per-stream interrupt enables, same order as status bits 7..0 |
| ctl_en | input | 1 | Controller interrupt enable |
| glb_en | input | 1 | Master interrupt enable |
| rd_stb | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the source flags and enables change only between clock edges and are stable at each edge. They also assume that wall_load and counting are not needed at the same edge as a checked increment. The stimulus is applied on the falling clock edge, and wall_en is held low around every wall count read, so each value captured is known exactly. The wrap is reached by preloading FFFFFFFEh rather than by counting up from zero.

// File: rtl/audirq_pkg.sv
package audirq_pkg;
   localparam int REG_W    = 32;
   localparam int N_STRM   = 8;
   localparam int GLB_BIT  = 31;
   localparam int CTL_BIT  = 30;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STS  = 2'd1,
      SEL_WALL = 2'd2
   } rd_sel_e;

   function automatic rd_sel_e decode_ofs(input logic [7:0] ofs,
                                          input logic [7:0] sts_ofs,
                                          input logic [7:0] wall_ofs);
      if (ofs == sts_ofs)       return SEL_STS;
      else if (ofs == wall_ofs) return SEL_WALL;
      else                      return SEL_NONE;
   endfunction
endpackage

// File: rtl/audirq_strm_or.sv
module audirq_strm_or #(
   parameter int N_GRP   = 8,
   parameter int GRP_W   = 3,
   localparam int BUS_W  = N_GRP * GRP_W
) (
   input  logic [BUS_W-1:0] flags,
   output logic [N_GRP-1:0] summ
);
   if (GRP_W < 1) begin : g_bad_w
      $error("GRP_W must be at least 1");
   end

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      if (GRP_W == 1) begin : g_one
         assign summ[g] = flags[g];
      end else begin : g_many
         assign summ[g] = |flags[g*GRP_W +: GRP_W];
      end
   end
endmodule

// File: rtl/audirq_wall.sv
module audirq_wall #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_w
      $error("CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             count <= '0;
      else if (load)          count <= load_val;
      else if (run && tick)   count <= count + 1'b1;
   end

   assert_wall_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && run && tick && count == CNT_MAX) |=> (count == '0));

   assert_wall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !(run && tick)) |=> $stable(count));

   assert_wall_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && run && tick && count != CNT_MAX) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/audirq_hub.sv
module audirq_hub
   import audirq_pkg::*;
#(
   parameter int STRM_FLAGS = 3,
   parameter int WALL_W     = 32,
   parameter logic [7:0] STS_OFS  = 8'h24,
   parameter logic [7:0] WALL_OFS = 8'h30,
   localparam int N_HALF  = N_STRM / 2,
   localparam int HALF_W  = N_HALF * STRM_FLAGS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wake_evt,
   input  logic              link_tick,
   input  logic              wall_en,
   input  logic              wall_load,
   input  logic [31:0]       wall_load_val,
   input  logic [HALF_W-1:0] cap_flags,
   input  logic [HALF_W-1:0] play_flags,
   input  logic              rsp_flag,
   input  logic              rsp_ovr_flag,
   input  logic              sdin_chg_flag,
   input  logic [7:0]        strm_en,
   input  logic              ctl_en,
   input  logic              glb_en,
   input  logic              rd_stb,
   input  logic [7:0]        rd_addr,
   output logic [31:0]       rd_data,
   output logic              irq
);
   if (WALL_W != REG_W) begin : g_bad_wall
      $error("WALL_W must match the 32-bit register width");
   end
   if (STS_OFS == WALL_OFS) begin : g_bad_ofs
      $error("register offsets must differ");
   end

   logic [N_STRM-1:0] strm_summ;
   logic              ctl_summ;
   logic [REG_W-1:0]  sts_word;
   logic [WALL_W-1:0] wall_cnt;
   logic              irq_d;
   rd_sel_e           rd_sel;

   audirq_strm_or #(.N_GRP(N_STRM), .GRP_W(STRM_FLAGS)) u_strm_or (
      .flags ({play_flags, cap_flags}),
      .summ  (strm_summ)
   );

   audirq_strm_or #(.N_GRP(1), .GRP_W(3)) u_ctl_or (
      .flags ({sdin_chg_flag, rsp_ovr_flag, rsp_flag}),
      .summ  (ctl_summ)
   );

   audirq_wall #(.CNT_W(WALL_W)) u_wall (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (link_tick),
      .run      (wall_en),
      .load     (wall_load),
      .load_val (wall_load_val),
      .count    (wall_cnt)
   );

   always_comb begin
      sts_word                = '0;
      sts_word[N_STRM-1:0]    = strm_summ;
      sts_word[CTL_BIT]       = ctl_summ;
      sts_word[GLB_BIT]       = ctl_summ | (|strm_summ);
   end

   assign irq_d = glb_en & ((ctl_summ & ctl_en) | (|(strm_summ & strm_en)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= irq_d;
   end

   assign rd_sel = decode_ofs(rd_addr, STS_OFS, WALL_OFS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_stb) begin
         unique case (rd_sel)
            SEL_STS:  rd_data <= sts_word;
            SEL_WALL: rd_data <= wall_cnt;
            default:  rd_data <= '0;
         endcase
      end
   end

   assert_glb_or_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sts_word[GLB_BIT] == (ctl_summ | (|strm_summ)) && sts_word[GLB_BIT] == |sts_word[30:0]);

   assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_stb) && $past(rd_addr) == STS_OFS) |-> (rd_data[29:8] == '0));

   assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> !irq);

   assert_irq_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_en && ctl_en && (rsp_flag || rsp_ovr_flag || sdin_chg_flag)) |=> irq);

   assert_wake_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_evt && $stable(sts_word)) |=> (irq == $past(irq_d)));

   assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rd_data));

   assert_rd_other_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_addr != STS_OFS && rd_addr != WALL_OFS) |=> (rd_data == '0));
endmodule

// File: tb/audirq_hub_bench.sv
module audirq_hub_bench;
   localparam int F = 3;
   localparam int HW = 4 * F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wake_evt = 0, link_tick = 0, wall_en = 0, wall_load = 0;
   logic [31:0] wall_load_val = '0;
   logic [HW-1:0] cap_flags = '0, play_flags = '0;
   logic rsp_flag = 0, rsp_ovr_flag = 0, sdin_chg_flag = 0;
   logic [7:0] strm_en = '0;
   logic ctl_en = 0, glb_en = 0, rd_stb = 0;
   logic [7:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic irq;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   audirq_hub #(.STRM_FLAGS(F)) u_audirq_hub (
      .clk(clk), .rst_n(rst_n), .wake_evt(wake_evt), .link_tick(link_tick),
      .wall_en(wall_en), .wall_load(wall_load), .wall_load_val(wall_load_val),
      .cap_flags(cap_flags), .play_flags(play_flags), .rsp_flag(rsp_flag),
      .rsp_ovr_flag(rsp_ovr_flag), .sdin_chg_flag(sdin_chg_flag),
      .strm_en(strm_en), .ctl_en(ctl_en), .glb_en(glb_en), .rd_stb(rd_stb),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rd_addr = a; rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      d = rd_data;
   endtask

   task automatic clear_src();
      cap_flags = '0; play_flags = '0;
      rsp_flag = 0; rsp_ovr_flag = 0; sdin_chg_flag = 0;
   endtask

   task automatic t_reset();
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 rd_data", rd_data, 32'h0);
      rst_n = 1'b1; cyc(1);
      begin logic [31:0] d; rd(8'h30, d); check("R1 wall", d, 32'h0); end
   endtask

   task automatic t_stream_map();
      logic [31:0] d;
      for (int s = 0; s < 8; s++) begin
         for (int f = 0; f < F; f++) begin
            clear_src();
            if (s < 4) cap_flags[s*F+f] = 1'b1;
            else       play_flags[(s-4)*F+f] = 1'b1;
            rd(8'h24, d);
            check("R4 stream bit", d, 32'h8000_0000 | (32'h1 << s));
         end
      end
      clear_src();
      cap_flags = {HW{1'b1}}; play_flags = {HW{1'b1}};
      rd(8'h24, d);
      check("R5 reserved zero", d & 32'h3FFF_FF00, 32'h0);
      check("R2 all streams", d, 32'h8000_00FF);
      clear_src();
      rd(8'h24, d);
      check("R2 idle", d, 32'h0);
   endtask

   task automatic t_ctrl();
      logic [31:0] d;
      for (int k = 0; k < 3; k++) begin
         clear_src();
         rsp_flag = (k == 0); rsp_ovr_flag = (k == 1); sdin_chg_flag = (k == 2);
         rd(8'h24, d);
         check("R3 ctl source", d, 32'hC000_0000);
      end
      clear_src();
   endtask

   task automatic t_enable_indep();
      logic [31:0] d0, d1;
      cap_flags[F] = 1'b1; rsp_ovr_flag = 1'b1;
      strm_en = '0; ctl_en = 0; glb_en = 0;
      rd(8'h24, d0);
      strm_en = 8'hFF; ctl_en = 1; glb_en = 1;
      rd(8'h24, d1);
      check("R6 enables ignored", d1, d0);
      check("R6 value", d0, 32'hC000_0002);
      strm_en = '0; ctl_en = 0; glb_en = 0;
      clear_src(); cyc(1);
   endtask

   task automatic t_irq();
      play_flags[2*F] = 1'b1;
      strm_en = 8'h40; glb_en = 1'b1;
      check("R7 not before edge", {31'b0, irq}, 32'h0);
      cyc(1);
      check("R7 stream enabled", {31'b0, irq}, 32'h1);
      strm_en = 8'hBF; cyc(1);
      check("R7 wrong enable", {31'b0, irq}, 32'h0);
      strm_en = 8'h40; glb_en = 1'b0; cyc(1);
      check("R7 master off", {31'b0, irq}, 32'h0);
      clear_src(); sdin_chg_flag = 1'b1; glb_en = 1'b1; strm_en = '0; ctl_en = 1'b1;
      cyc(1);
      check("R7 controller", {31'b0, irq}, 32'h1);
      ctl_en = 1'b0; cyc(1);
      check("R7 ctl disabled", {31'b0, irq}, 32'h0);
      ctl_en = 1'b1; cyc(1);
   endtask

   task automatic t_wake();
      logic [31:0] d;
      wake_evt = 1'b1; cyc(1); wake_evt = 1'b0;
      check("R8 irq kept", {31'b0, irq}, 32'h1);
      rd(8'h24, d);
      check("R8 status kept", d, 32'hC000_0000);
      ctl_en = 0; glb_en = 0; clear_src(); cyc(1);
   endtask

   task automatic t_wall();
      logic [31:0] d;
      wall_en = 1'b1; link_tick = 1'b1; cyc(5); link_tick = 1'b0; cyc(3);
      wall_en = 1'b0;
      rd(8'h30, d);
      check("R9 count ticks", d, 32'd5);
      link_tick = 1'b1; cyc(4); link_tick = 1'b0;
      rd(8'h30, d);
      check("R9 hold when off", d, 32'd5);
      wall_load = 1'b1; wall_load_val = 32'hFFFF_FFFE; wall_en = 1'b1; link_tick = 1'b1;
      cyc(1); wall_load = 1'b0; wall_en = 1'b0; link_tick = 1'b0;
      rd(8'h30, d);
      check("R10 load priority", d, 32'hFFFF_FFFE);
      wall_en = 1'b1; link_tick = 1'b1; cyc(1); wall_en = 1'b0; link_tick = 1'b0;
      rd(8'h30, d);
      check("R10 max", d, 32'hFFFF_FFFF);
      wall_en = 1'b1; link_tick = 1'b1; cyc(1); wall_en = 1'b0; link_tick = 1'b0;
      rd(8'h30, d);
      check("R10 wrap", d, 32'h0);
   endtask

   task automatic t_read_port();
      logic [31:0] d;
      cap_flags[0] = 1'b1;
      rd(8'h24, d);
      check("R11 status", d, 32'h8000_0001);
      rd(8'h28, d);
      check("R11 other offset", d, 32'h0);
      rd(8'h24, d);
      cap_flags[0] = 1'b0; cyc(2);
      check("R11 hold", rd_data, 32'h8000_0001);
      rd(8'h31, d);
      check("R11 near offset", d, 32'h0);
   endtask

   task automatic t_reset_again();
      logic [31:0] d;
      wall_load = 1'b1; wall_load_val = 32'h1234_5678; cyc(1); wall_load = 1'b0;
      rst_n = 1'b0; cyc(1); rst_n = 1'b1; cyc(1);
      rd(8'h30, d);
      check("R12 wall cleared", d, 32'h0);
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      cyc(2);
      t_reset();
      t_stream_map();
      t_ctrl();
      t_enable_indep();
      t_irq();
      t_wake();
      t_wall();
      t_read_port();
      t_reset_again();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule